// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Unit

This block chooses where each of the two execute-stage ALU operands comes from in a five-stage load/store pipeline. It looks at the two source register numbers of the instruction now in execute. It compares each one against the destination number and write enable of the two older instructions further down the pipe: the one in the memory stage and the one in write-back. From that comparison it builds a 2-bit source code per operand. That code steers a three-way multiplexer, which picks the register-file value, the memory-stage ALU result or the write-back value.

The second operand has one more step after its bypass multiplexer: a choice between the bypassed register value and the sign-extended immediate. The bypassed value, taken before that choice, is also driven out as the store data. The destination numbers arrive already resolved: the pipe has chosen the rd or rt field for each instruction, so a load's target is matched like any other write. The unit has no clock and no state. Every output follows its inputs within the same cycle.

Top module: `operand_bypass_unit`

## Requirements
- R1: An operand's code is 2'b10, and its operand equals `mem_result`, when `mem_wr_en` is 1, `mem_dst_idx` is nonzero and `mem_dst_idx` equals that operand's source number.
- R2: An operand's code is 2'b01, and its operand equals `wb_value`, when all of these hold: `wb_wr_en` is 1, `wb_dst_idx` is nonzero, `wb_dst_idx` equals the source number, and `mem_dst_idx` differs from the source number. The last condition applies whatever the value of `mem_wr_en`.
- R3: When both older stages write the same nonzero source register, the code is 2'b10, so the memory-stage result wins.
- R4: A source number of 0 always gets code 2'b00 and the register-file value, even when a stage writes register 0.
- R5: A stage whose write enable is 0 never supplies an operand.
- R6: Operand A follows only `ex_src_a_idx` and operand B follows only `ex_src_b_idx`; each code is found on its own.
- R7: `alu_in_b` equals `ex_imm` when `ex_use_imm` is 1, and equals the bypassed B value otherwise. `store_data` always equals the bypassed B value.
- R8: The code 2'b11 is never produced on either select output.
- R9: The unit has no clock: every output settles from the current inputs within the same cycle, and code 2'b00 passes the register-file value through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a_idx | input | 5 | First source register number of the execute-stage instruction |
| ex_src_b_idx | input | 5 | Second source register number of the execute-stage instruction |
| ex_rf_a | input | 32 | Register-file value read for the first source |
| ex_rf_b | input | 32 | Register-file value read for the second source |
| ex_imm | input | 32 | Sign-extended immediate |
| ex_use_imm | input | 1 | 1 selects the immediate as the second ALU input |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_dst_idx | input | 5 | Memory-stage destination register number |
| mem_result | input | 32 | Memory-stage ALU result |
| wb_wr_en | input | 1 | Write-back-stage instruction writes a register |
| wb_dst_idx | input | 5 | Write-back-stage destination register number |
| wb_value | input | 32 | Value being written back |
| fwd_sel_a | output | 2 | Source code for operand A (00 register file, 01 write-back, 10 memory stage) |
| fwd_sel_b | output | 2 | Source code for operand B, same encoding |
| alu_in_a | output | 32 | First ALU input |
| alu_in_b | output | 32 | Second ALU input, after the immediate choice |
| store_data | output | 32 | Bypassed second operand, before the immediate choice |

## Verification
Two things can happen in the same cycle. The two older stages can both claim the same source register, and operand B can both be bypassed and be replaced by the immediate. The bench provokes the first with a memory-stage and a write-back-stage write to one register. It judges that only the memory result reaches the ALU, and that a non-writing memory-stage instruction naming that register still blocks the write-back path. It provokes the second by setting the immediate select while the B source matches. It judges that `alu_in_b` carries the immediate while `store_data` carries the bypassed value. A reference model then compares all outputs every cycle under random register numbers drawn from a small range, so that matches happen often.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

    localparam int unsigned REG_IDX_W = 5;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned NUM_OPS   = 2;

    typedef enum logic [1:0] {
        SRC_REGFILE   = 2'b00,
        SRC_WRITEBACK = 2'b01,
        SRC_EXMEM     = 2'b10
    } bypass_src_e;

    typedef struct packed {
        logic mem_hit;      // memory stage writes this nonzero register
        logic wb_hit;       // write-back stage writes this nonzero register
        logic mem_name_eq;  // memory-stage destination field equals source
    } hit_vec_t;

    function automatic bypass_src_e pick_source(input hit_vec_t h);
        if (h.mem_hit)
            return SRC_EXMEM;
        else if (h.wb_hit && !h.mem_name_eq)
            return SRC_WRITEBACK;
        else
            return SRC_REGFILE;
    endfunction

endpackage

// File: rtl/bypass_match.sv
module bypass_match
    import bypass_pkg::*;
#(
    parameter int unsigned IDX_W = REG_IDX_W
) (
    input  logic [IDX_W-1:0] src_idx,
    input  logic             mem_wr_en,
    input  logic [IDX_W-1:0] mem_dst_idx,
    input  logic             wb_wr_en,
    input  logic [IDX_W-1:0] wb_dst_idx,
    output hit_vec_t         hits
);
    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    logic src_nonzero;

    always_comb begin
        src_nonzero      = (src_idx != ZERO_IDX);
        hits.mem_name_eq = (mem_dst_idx == src_idx);
        hits.mem_hit     = mem_wr_en && src_nonzero && hits.mem_name_eq;
        hits.wb_hit      = wb_wr_en && src_nonzero && (wb_dst_idx == src_idx);
    end

endmodule

// File: rtl/bypass_operand_mux.sv
module bypass_operand_mux
    import bypass_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  bypass_src_e    sel,
    input  logic [W-1:0]   rf_val,
    input  logic [W-1:0]   exmem_val,
    input  logic [W-1:0]   wb_val,
    output logic [W-1:0]   operand
);
    always_comb begin
        unique case (sel)
            SRC_EXMEM:     operand = exmem_val;
            SRC_WRITEBACK: operand = wb_val;
            default:       operand = rf_val;
        endcase
    end

endmodule

// File: rtl/operand_bypass_unit.sv
module operand_bypass_unit
    import bypass_pkg::*;
#(
    parameter int unsigned IDX_W = REG_IDX_W,
    parameter int unsigned W     = DATA_W
) (
    input  logic [IDX_W-1:0] ex_src_a_idx,
    input  logic [IDX_W-1:0] ex_src_b_idx,
    input  logic [W-1:0]     ex_rf_a,
    input  logic [W-1:0]     ex_rf_b,
    input  logic [W-1:0]     ex_imm,
    input  logic             ex_use_imm,
    input  logic             mem_wr_en,
    input  logic [IDX_W-1:0] mem_dst_idx,
    input  logic [W-1:0]     mem_result,
    input  logic             wb_wr_en,
    input  logic [IDX_W-1:0] wb_dst_idx,
    input  logic [W-1:0]     wb_value,
    output logic [1:0]       fwd_sel_a,
    output logic [1:0]       fwd_sel_b,
    output logic [W-1:0]     alu_in_a,
    output logic [W-1:0]     alu_in_b,
    output logic [W-1:0]     store_data
);
    localparam int unsigned OPS = NUM_OPS;

    logic [IDX_W-1:0] src_idx [OPS];
    logic [W-1:0]     rf_val  [OPS];
    logic [W-1:0]     byp_val [OPS];
    bypass_src_e      src_sel [OPS];
    hit_vec_t         hits    [OPS];

    assign src_idx[0] = ex_src_a_idx;
    assign src_idx[1] = ex_src_b_idx;
    assign rf_val[0]  = ex_rf_a;
    assign rf_val[1]  = ex_rf_b;

    for (genvar g = 0; g < OPS; g++) begin : g_op
        bypass_match #(.IDX_W(IDX_W)) i_match (
            .src_idx     (src_idx[g]),
            .mem_wr_en   (mem_wr_en),
            .mem_dst_idx (mem_dst_idx),
            .wb_wr_en    (wb_wr_en),
            .wb_dst_idx  (wb_dst_idx),
            .hits        (hits[g])
        );

        assign src_sel[g] = pick_source(hits[g]);

        bypass_operand_mux #(.W(W)) i_mux (
            .sel       (src_sel[g]),
            .rf_val    (rf_val[g]),
            .exmem_val (mem_result),
            .wb_val    (wb_value),
            .operand   (byp_val[g])
        );
    end

    assign fwd_sel_a  = src_sel[0];
    assign fwd_sel_b  = src_sel[1];
    assign alu_in_a   = byp_val[0];
    assign store_data = byp_val[1];
    assign alu_in_b   = ex_use_imm ? ex_imm : byp_val[1];

endmodule

// File: rtl/bypass_checker.sv
module bypass_checker #(
    parameter int unsigned IDX_W = 5,
    parameter int unsigned W     = 32
) (
    input logic [IDX_W-1:0] ex_src_a_idx,
    input logic [IDX_W-1:0] ex_src_b_idx,
    input logic [W-1:0]     ex_imm,
    input logic             ex_use_imm,
    input logic             mem_wr_en,
    input logic [IDX_W-1:0] mem_dst_idx,
    input logic [W-1:0]     mem_result,
    input logic             wb_wr_en,
    input logic [W-1:0]     wb_value,
    input logic [1:0]       fwd_sel_a,
    input logic [1:0]       fwd_sel_b,
    input logic [W-1:0]     alu_in_a,
    input logic [W-1:0]     alu_in_b,
    input logic [W-1:0]     store_data
);
    always_comb begin
        AST_SEL_LEGAL: assert (fwd_sel_a != 2'b11 && fwd_sel_b != 2'b11); // R8
        AST_ZERO_SRC_A: assert (ex_src_a_idx != '0 || fwd_sel_a == 2'b00); // R4
        AST_ZERO_SRC_B: assert (ex_src_b_idx != '0 || fwd_sel_b == 2'b00); // R4
        AST_MEM_NEEDS_WR: assert (!(fwd_sel_a == 2'b10 || fwd_sel_b == 2'b10) || mem_wr_en); // R5
        AST_WB_NEEDS_WR: assert (!(fwd_sel_a == 2'b01 || fwd_sel_b == 2'b01) || wb_wr_en); // R5
        AST_NEWEST_WINS: assert (!(mem_wr_en && ex_src_a_idx != '0 && mem_dst_idx == ex_src_a_idx) || fwd_sel_a == 2'b10); // R3
        AST_MEM_VALUE_A: assert (fwd_sel_a != 2'b10 || alu_in_a == mem_result); // R1
        AST_WB_VALUE_A: assert (fwd_sel_a != 2'b01 || alu_in_a == wb_value); // R2
        AST_IMM_AFTER_MUX: assert (ex_use_imm ? (alu_in_b == ex_imm) : (alu_in_b == store_data)); // R7
    end

endmodule

bind operand_bypass_unit bypass_checker #(.IDX_W(IDX_W), .W(W)) i_bypass_checker (
    .ex_src_a_idx (ex_src_a_idx),
    .ex_src_b_idx (ex_src_b_idx),
    .ex_imm       (ex_imm),
    .ex_use_imm   (ex_use_imm),
    .mem_wr_en    (mem_wr_en),
    .mem_dst_idx  (mem_dst_idx),
    .mem_result   (mem_result),
    .wb_wr_en     (wb_wr_en),
    .wb_value     (wb_value),
    .fwd_sel_a    (fwd_sel_a),
    .fwd_sel_b    (fwd_sel_b),
    .alu_in_a     (alu_in_a),
    .alu_in_b     (alu_in_b),
    .store_data   (store_data)
);

// File: tb/test_operand_bypass_unit.sv
module test_operand_bypass_unit;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [4:0]  sa, sb, md, wd;
    logic [31:0] rfa, rfb, imm, mres, wval;
    logic        useimm, mwe, wwe;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] alu_a, alu_b, st_d;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    operand_bypass_unit i_operand_bypass_unit (
        .ex_src_a_idx (sa),   .ex_src_b_idx (sb),
        .ex_rf_a      (rfa),  .ex_rf_b      (rfb),
        .ex_imm       (imm),  .ex_use_imm   (useimm),
        .mem_wr_en    (mwe),  .mem_dst_idx  (md),   .mem_result (mres),
        .wb_wr_en     (wwe),  .wb_dst_idx   (wd),   .wb_value   (wval),
        .fwd_sel_a    (sel_a), .fwd_sel_b   (sel_b),
        .alu_in_a     (alu_a), .alu_in_b    (alu_b), .store_data (st_d)
    );

    // Reference: scan producers newest first; the first whose destination
    // names the source decides. Register 0 is never bypassed.
    function automatic logic [1:0] ref_code(input logic [4:0] src);
        if (src == 0) return 2'b00;
        if (md == src) return mwe ? 2'b10 : 2'b00;
        if (wd == src && wwe) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [31:0] ref_val(input logic [1:0] c, input logic [31:0] rf);
        if (c == 2'b10) return mres;
        if (c == 2'b01) return wval;
        return rf;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    task automatic compare(input string tag);
        logic [1:0]  ea, eb;
        logic [31:0] va, vb;
        ea = ref_code(sa);
        eb = ref_code(sb);
        va = ref_val(ea, rfa);
        vb = ref_val(eb, rfb);
        chk(tag, "sel_a", {30'd0, sel_a}, {30'd0, ea});
        chk(tag, "sel_b", {30'd0, sel_b}, {30'd0, eb});
        chk(tag, "alu_in_a", alu_a, va);
        chk(tag, "alu_in_b", alu_b, useimm ? imm : vb);
        chk(tag, "store_data", st_d, vb);
        chk("R8", "sel_not_11", {31'd0, (sel_a == 2'b11 || sel_b == 2'b11)}, 32'd0);
    endtask

    task automatic put(input logic [4:0] a, input logic [4:0] b, input logic ui,
                       input logic me, input logic [4:0] mdi, input logic we, input logic [4:0] wdi);
        sa = a; sb = b; useimm = ui; mwe = me; md = mdi; wwe = we; wd = wdi;
        rfa = 32'hA000_0000 | 32'(a); rfb = 32'hB000_0000 | 32'(b);
        imm = 32'h0000_1234; mres = 32'hCAFE_0001; wval = 32'hBEEF_0002;
    endtask

    // one vector per clock: drive after the rising edge, compare at the falling edge
    task automatic step(input string tag, input logic [4:0] a, input logic [4:0] b, input logic ui,
                        input logic me, input logic [4:0] mdi, input logic we, input logic [4:0] wdi);
        @(posedge clk); #1;
        put(a, b, ui, me, mdi, we, wdi);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        put(0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare("R9");                              // idle: register-file pass-through
        step("R1", 3, 1, 0, 1, 3, 0, 0);            // back-to-back dependency
        step("R1", 1, 9, 0, 1, 9, 1, 2);
        step("R2", 2, 7, 0, 1, 9, 1, 7);            // one-gap dependency
        step("R2", 6, 1, 0, 0, 6, 1, 6);            // non-writing mem names source: blocks WB
        step("R3", 4, 4, 0, 1, 4, 1, 4);            // double hazard, newest wins
        step("R4", 0, 0, 0, 1, 0, 1, 0);            // writes to register zero
        step("R4", 0, 5, 0, 1, 0, 1, 5);
        step("R5", 5, 8, 0, 0, 5, 0, 8);            // write enables off
        step("R5", 11, 11, 0, 0, 3, 0, 11);
        step("R6", 12, 13, 0, 1, 12, 1, 13);        // A from mem, B from WB
        step("R6", 13, 12, 0, 1, 12, 1, 13);
        step("R7", 2, 14, 1, 1, 14, 0, 0);          // immediate after bypass
        step("R7", 2, 14, 1, 0, 0, 1, 14);
        // same-cycle response: change inputs with no clock edge between
        #1; put(9, 9, 0, 1, 9, 0, 0); #1;
        compare("R9");
        for (int i = 0; i < 400; i++) begin
            step("R6", 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)), 1'($urandom),
                 1'($urandom), 5'($urandom_range(0, 3)), 1'($urandom), 5'($urandom_range(0, 3)));
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule